// File: doc/BRIEF.md
# Exact-Division Quotient Unit

This block divides one WIDTH-bit operand by another when the dividend is known in advance to be a whole multiple of the divisor. Because no remainder can occur, the quotient follows from the equation dividend = divisor × quotient, taken modulo 2^WIDTH. The unit solves that equation from the least significant bit upward. It does not use a long-division loop.

The calculation has two steps. First, a cascade of conditional one-bit right shifts strips the divisor's trailing zeros. Every shift applied to the divisor is also applied to the dividend. After this step the divisor is odd. Second, a column solver finds each quotient bit in turn. Bit 0 is copied from the normalized dividend. Each higher bit is the dividend bit XOR the running column sum of the partial products already committed, including carries from lower columns. Carries out of the top column are dropped.

A select input chooses two's-complement (arithmetic) or unsigned (logical) shifting during normalization. A zero divisor raises a flag and forces the quotient to zero. By default the results are registered once. A parameter can make the unit purely combinational instead.

Top module: `exact_quotient_unit`

## Requirements
- R1: In registered mode (REG_OUT=1), driving rst_n low clears quotient_o and div_zero_o at once, without waiting for a clock edge. Both stay clear while rst_n is low.
- R2: With REG_OUT=1, the outputs show the result for the inputs present at the previous rising clock edge and hold it until the next edge. With REG_OUT=0, the outputs follow the inputs with no clock.
- R3: When divisor_i is odd (bit 0 = 1), quotient_o is the unique x in [0, 2^WIDTH) such that (divisor_i × x) mod 2^WIDTH equals dividend_i.
- R4: When divisor_i is nonzero and has k trailing zero bits, both operands are first shifted right by k. quotient_o is then the unique x such that (shifted divisor × x) mod 2^WIDTH equals the shifted dividend.
- R5: When signed_i = 1, each normalization shift refills the vacated top bit with the operand's current top bit. When signed_i = 0, the vacated top bit is refilled with 0.
- R6: Suppose the true product divisor × q fits in WIDTH bits: as an unsigned number when signed_i = 0, or as a two's-complement number when signed_i = 1. If dividend_i equals that product, quotient_o equals q.
- R7: When divisor_i is zero, div_zero_o is 1 and quotient_o is all zeros.
- R8: When divisor_i is nonzero, div_zero_o is 0.
- R9: When WIDTH = 1, quotient_o equals dividend_i AND divisor_i.
- R10: When divisor_i equals 1, quotient_o equals dividend_i in both signedness modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| dividend_i | input | WIDTH | Dividend; must be an exact multiple of the divisor |
| divisor_i | input | WIDTH | Divisor |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| quotient_o | output | WIDTH | Quotient modulo 2^WIDTH |
| div_zero_o | output | 1 | Set when the divisor is zero |

## Verification
Two kinds of internal fault look different at the ports.

- **Broken trailing-zero mask or wrong fill bit:** the quotient is wrong only for even divisors, and only in the upper bits. Only even divisors with particular dividend top bits expose it.
- **Broken carry in the column solver:** the fault corrupts every quotient bit above the first bad column. Any odd divisor with set bits above bit 0 shows it.

In registered mode, either fault appears on the first clock edge after the operands are applied, with no delay beyond that edge. For this reason, operands are swept exhaustively at a small width, so that every trailing-zero count, fill value and carry pattern is reached. The odd-divisor bit-0 identity and the unit-divisor pass-through are also checked on every cycle.

// File: rtl/exq_pkg.sv
package exq_pkg;

  // Bit shifted into the vacated top position by a normalizing right shift.
  function automatic logic vacated_fill(input logic twos_mode, input logic top_bit);
    return twos_mode & top_bit;
  endfunction

endpackage

// File: rtl/exq_normalize.sv
module exq_normalize #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  input  logic             twos_i,
  output logic [WIDTH-1:0] num_o,
  output logic [WIDTH-1:0] den_o
);
  import exq_pkg::*;

  if (WIDTH > 1) begin : g_cascade
    localparam int unsigned STAGES = WIDTH - 1;

    logic [WIDTH-1:0] num_s [WIDTH];
    logic [WIDTH-1:0] den_s [WIDTH];
    logic [STAGES:0]  low_zero;   // low_zero[s]: divisor bits below s all clear

    assign num_s[0]    = num_i;
    assign den_s[0]    = den_i;
    assign low_zero[0] = 1'b1;

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
      assign low_zero[s] = low_zero[s-1] & ~den_i[s-1];

      always_comb begin
        if (low_zero[s]) begin
          num_s[s] = {vacated_fill(twos_i, num_s[s-1][WIDTH-1]), num_s[s-1][WIDTH-1:1]};
          den_s[s] = {vacated_fill(twos_i, den_s[s-1][WIDTH-1]), den_s[s-1][WIDTH-1:1]};
        end else begin
          num_s[s] = num_s[s-1];
          den_s[s] = den_s[s-1];
        end
      end
    end

    assign num_o = num_s[STAGES];
    assign den_o = den_s[STAGES];
  end else begin : g_single
    logic unused_twos;
    assign unused_twos = twos_i;
    assign num_o = num_i;
    assign den_o = den_i;
  end

endmodule

// File: rtl/exq_solve.sv
module exq_solve #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] num_i,   // normalized dividend
  input  logic [WIDTH-1:0] den_i,   // normalized divisor, bit 0 expected set
  output logic [WIDTH-1:0] quo_o
);

  // Column sweep: accumulator holds divisor times the quotient bits chosen so
  // far; each new bit cancels the dividend bit in its own column.
  always_comb begin
    logic [WIDTH-1:0] partial;
    partial = '0;
    quo_o   = '0;
    for (int col = 0; col < WIDTH; col++) begin
      quo_o[col] = num_i[col] ^ partial[col];
      if (quo_o[col]) begin
        partial = partial + (den_i << col);
      end
    end
  end

endmodule

// File: rtl/exq_outreg.sv
module exq_outreg #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] quo_d,
  input  logic             zero_d,
  output logic [WIDTH-1:0] quo_q,
  output logic             zero_q
);

  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] quo_next;
    logic             zero_next;
    logic             load_en;

    assign load_en = 1'b1;   // result register loads every cycle

    always_comb begin
      quo_next  = quo_q;
      zero_next = zero_q;
      if (load_en) begin
        quo_next  = quo_d;
        zero_next = zero_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        quo_q  <= '0;
        zero_q <= 1'b0;
      end else begin
        quo_q  <= quo_next;
        zero_q <= zero_next;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign quo_q  = quo_d;
    assign zero_q = zero_d;
  end

endmodule

// File: rtl/exact_quotient_unit.sv
module exact_quotient_unit #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic             div_zero_o
);

  logic [WIDTH-1:0] num_n;
  logic [WIDTH-1:0] den_n;
  logic [WIDTH-1:0] quo_raw;
  logic [WIDTH-1:0] quo_next;
  logic             zero_den;

  exq_normalize #(.WIDTH(WIDTH)) u_norm (
    .num_i  (dividend_i),
    .den_i  (divisor_i),
    .twos_i (signed_i),
    .num_o  (num_n),
    .den_o  (den_n)
  );

  // After normalization an even divisor can only mean a zero divisor.
  assign zero_den = ~den_n[0];

  exq_solve #(.WIDTH(WIDTH)) u_solve (
    .num_i (num_n),
    .den_i (den_n),
    .quo_o (quo_raw)
  );

  assign quo_next = zero_den ? '0 : quo_raw;

  exq_outreg #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .quo_d  (quo_next),
    .zero_d (zero_den),
    .quo_q  (quotient_o),
    .zero_q (div_zero_o)
  );

endmodule

// File: rtl/exact_quotient_unit_chk.sv
module exact_quotient_unit_chk #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic [WIDTH-1:0] quotient_o,
  input logic             div_zero_o
);

  logic [WIDTH-1:0] a_ref;
  logic [WIDTH-1:0] b_ref;
  logic             ready;

  if (REG_OUT) begin : g_track
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_ref <= '0;
        b_ref <= '0;
        ready <= 1'b0;
      end else begin
        a_ref <= dividend_i;
        b_ref <= divisor_i;
        ready <= 1'b1;
      end
    end

    // R1: outputs held clear during reset
    assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (quotient_o == '0 && !div_zero_o));
  end else begin : g_direct
    assign a_ref = dividend_i;
    assign b_ref = divisor_i;
    assign ready = 1'b1;
  end

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && b_ref == '0) |-> div_zero_o);

  assert_zero_quotient_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero_o |-> (quotient_o == '0));

  assert_nonzero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && b_ref != '0) |-> !div_zero_o);

  assert_odd_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && b_ref[0]) |-> (quotient_o[0] == a_ref[0]));

  assert_unit_divisor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && b_ref == WIDTH'(1)) |-> (quotient_o == a_ref));

endmodule

bind exact_quotient_unit exact_quotient_unit_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .quotient_o (quotient_o),
  .div_zero_o (div_zero_o)
);

// File: tb/exact_quotient_unit_test.sv
`timescale 1ns/1ps
module exact_quotient_unit_test;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [7:0] a8, b8, q8;
  logic       s8, z8;
  logic [3:0] a4, b4, q4;
  logic       s4, z4;
  logic [0:0] a1, b1, q1;
  logic       s1, z1;

  int n_chk = 0;
  int n_err = 0;

  exact_quotient_unit #(.WIDTH(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .dividend_i(a8), .divisor_i(b8), .signed_i(s8),
    .quotient_o(q8), .div_zero_o(z8));

  exact_quotient_unit #(.WIDTH(4), .REG_OUT(1'b1)) uut_w4 (
    .clk(clk), .rst_n(rst_n), .dividend_i(a4), .divisor_i(b4), .signed_i(s4),
    .quotient_o(q4), .div_zero_o(z4));

  exact_quotient_unit #(.WIDTH(1), .REG_OUT(1'b0)) uut_w1 (
    .clk(clk), .rst_n(rst_n), .dividend_i(a1), .divisor_i(b1), .signed_i(s1),
    .quotient_o(q1), .div_zero_o(z1));

  // Layout: [25:18] dividend, [17:10] divisor, [9] signed, [8:1] quotient, [0] zero flag
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {8'h2A, 8'h06, 1'b0, 8'h07, 1'b0},
    {8'hC8, 8'h08, 1'b0, 8'h19, 1'b0},
    {8'hF4, 8'h04, 1'b1, 8'hFD, 1'b0},
    {8'hF4, 8'hFC, 1'b1, 8'h03, 1'b0},
    {8'h80, 8'h80, 1'b1, 8'h01, 1'b0},
    {8'h80, 8'h80, 1'b0, 8'h01, 1'b0},
    {8'hFE, 8'hFE, 1'b0, 8'h01, 1'b0},
    {8'h55, 8'h00, 1'b0, 8'h00, 1'b1},
    {8'h00, 8'h05, 1'b0, 8'h00, 1'b0},
    {8'hE1, 8'h0F, 1'b0, 8'h0F, 1'b0},
    {8'h81, 8'h7F, 1'b1, 8'hFF, 1'b0},
    {8'hF4, 8'h04, 1'b0, 8'h3D, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Reference from the requirements: strip trailing zeros, then search for x.
  function automatic void model(input int w, input int a, input int b, input bit sg,
                                output int q, output bit z);
    int m, aa, bb, top;
    m   = (1 << w) - 1;
    aa  = a & m;
    bb  = b & m;
    top = 1 << (w - 1);
    q   = 0;
    z   = 1'b0;
    if (bb == 0) begin
      z = 1'b1;
      return;
    end
    while ((bb & 1) == 0) begin
      aa = (aa >> 1) | ((sg && (aa & top) != 0) ? top : 0);
      bb = (bb >> 1) | ((sg && (bb & top) != 0) ? top : 0);
    end
    for (int x = 0; x <= m; x++) begin
      if (((bb * x) & m) == aa) begin
        q = x;
        break;
      end
    end
  endfunction

  task automatic apply8(input logic [7:0] a, input logic [7:0] b, input logic s);
    a8 = a; b8 = b; s8 = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int eq, ew;
    bit ez;
    rst_n = 1'b0;
    a8 = 8'h5A; b8 = 8'h00; s8 = 1'b0;
    a4 = 4'h3;  b4 = 4'h0;  s4 = 1'b0;
    a1 = 1'b0;  b1 = 1'b0;  s1 = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset quotient", 32'(q8), 32'h0);
    check("R1 reset flag", 32'(z8), 32'h0);
    check("R1 reset quotient w4", 32'(q4), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: exact quotients and zero divisor
    for (int i = 0; i < NV; i++) begin
      apply8(VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
      check("R6/R7 table quotient", 32'(q8), 32'(VEC[i][8:1]));
      check("R7/R8 table flag", 32'(z8), 32'(VEC[i][0]));
    end

    // R5: same operands, both fill modes
    apply8(8'hF4, 8'h04, 1'b1);
    check("R5 arithmetic fill", 32'(q8), 32'hFD);
    apply8(8'hF4, 8'h04, 1'b0);
    check("R5 logical fill", 32'(q8), 32'h3D);

    // R10: unit divisor
    apply8(8'hA7, 8'h01, 1'b0);
    check("R10 unit divisor unsigned", 32'(q8), 32'hA7);
    apply8(8'hA7, 8'h01, 1'b1);
    check("R10 unit divisor signed", 32'(q8), 32'hA7);

    // R7 / R8 directed
    apply8(8'h00, 8'h00, 1'b1);
    check("R7 zero divisor flag", 32'(z8), 32'h1);
    check("R7 zero divisor quotient", 32'(q8), 32'h0);
    apply8(8'h00, 8'h80, 1'b0);
    check("R8 nonzero divisor flag", 32'(z8), 32'h0);

    // R2: registered timing; output holds until the clock edge
    apply8(8'hC8, 8'h08, 1'b0);
    a8 = 8'h2A; b8 = 8'h06; s8 = 1'b0;
    #1;
    check("R2 holds before edge", 32'(q8), 32'h19);
    @(negedge clk);
    check("R2 updates after edge", 32'(q8), 32'h07);

    // R1: asynchronous reset mid-cycle
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear quotient", 32'(q8), 32'h0);
    check("R1 async clear flag", 32'(z8), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive WIDTH=4: every divisor, quotient and mode
    for (int b = 0; b < 16; b++) begin
      for (int q = 0; q < 16; q++) begin
        for (int s = 0; s < 2; s++) begin
          a4 = 4'((b * q) & 15); b4 = 4'(b); s4 = 1'(s);
          @(negedge clk);
          model(4, (b * q) & 15, b, 1'(s), eq, ez);
          if (b == 0) begin
            check("R7 w4 quotient", 32'(q4), 32'h0);
            check("R7 w4 flag", 32'(z4), 32'h1);
          end else if ((b & 1) == 1) begin
            check("R3 w4 odd divisor", 32'(q4), 32'(eq));
            check("R8 w4 flag", 32'(z4), 32'h0);
          end else begin
            check("R4 w4 even divisor", 32'(q4), 32'(eq));
          end
          ew = (s == 1) ? ((b >= 8 ? b - 16 : b) * (q >= 8 ? q - 16 : q)) : (b * q);
          if (b != 0 && ((s == 0 && ew < 16) || (s == 1 && ew >= -8 && ew <= 7)))
            check("R6 w4 exact", 32'(q4), 32'(q));
        end
      end
    end

    // Random WIDTH=8
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] rb, rq, ra;
      logic       rs;
      int         sp;
      rb = 8'($urandom);
      rq = 8'($urandom);
      rs = 1'($urandom);
      if (n % 16 == 0) rb = rb & 8'hF0;
      ra = 8'(rb * rq);
      apply8(ra, rb, rs);
      model(8, int'(ra), int'(rb), rs, eq, ez);
      if (rb[0]) check("R3 w8 odd divisor", 32'(q8), 32'(eq));
      else       check("R4 w8 even or zero divisor", 32'(q8), 32'(eq));
      check("R7/R8 w8 flag", 32'(z8), 32'(ez));
      sp = rs ? (int'($signed(rb)) * int'($signed(rq))) : (int'(rb) * int'(rq));
      if (rb != 0 && ((!rs && sp < 256) || (rs && sp >= -128 && sp <= 127)))
        check("R6 w8 exact", 32'(q8), 32'(rq));
    end

    // WIDTH=1, combinational variant
    for (int v = 0; v < 8; v++) begin
      a1 = 1'(v); b1 = 1'(v >> 1); s1 = 1'(v >> 2);
      #1;
      check("R9 w1 quotient", 32'(q1), 32'(v & (v >> 1) & 1));
      check("R2 w1 combinational flag", 32'(z1), 32'(((v >> 1) & 1) == 0));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule